// File: doc/BRIEF.md
# Framed Packet Burst Generator

This block produces bursts of framed test packets on a 64-bit AXI4-Stream master. Every packet opens with a packed header beat that carries a sequence number, an end-of-burst marker, a has-time marker, a length field and a stream ID. The first packet of a burst can carry a 64-bit timestamp beat straight after its header. A payload of 32-bit samples that count upward follows, two samples per beat.

A control port holds the burst description: packet count, payload length in 32-bit words, sequence seed, stream ID, timestamp, a timestamp request flag, a payload mode and a 16-bit seed. A one-cycle start strobe loads all of it. The block raises `busy` until the burst is sent and then pulses `done`. It is meant as a stimulus source in front of a packet-processing block under test.

Top module: `pkt_burst_gen`

## Requirements
- R1: A header beat has bit 63 = 0, bit 62 = 0, bit 61 = has-time, bit 60 = end-of-burst, bits 59:48 = sequence number, bits 47:32 = length field and bits 31:0 = the stream ID latched at start.
- R2: The length field is the payload word count plus 2, plus a further 2 when the packet carries a timestamp, taken modulo 2^16.
- R3: When the timestamp flag is set at start, the first packet has has-time = 1 and its second beat is the 64-bit timestamp. Every later packet has has-time = 0 and no timestamp beat.
- R4: End-of-burst is 1 only in the header of the last packet of a burst. A one-packet burst sets it on that packet.
- R5: The first packet uses the sequence seed. Each later packet adds one, wrapping modulo 4096.
- R6: A packet has ceil(len/2) payload beats. Each beat holds samples s and s+1, with s in bits 63:32 and s+1 in bits 31:0, and s rises by 2 from one beat to the next.
- R7: m_tlast is 1 on the final payload beat of each packet and 0 on every other beat.
- R8: In ramp mode (cfg_seed_mode = 0) the first packet starts at sample 0. Each later packet starts at the previous packet's first sample plus len.
- R9: In seed mode (cfg_seed_mode = 1) each packet's first sample is {4'b0, sequence number, cfg_seed[15:0]}.
- R10: A beat is transferred only when m_tvalid and m_tready are both 1. While m_tvalid = 1 and m_tready = 0, m_tvalid, m_tdata and m_tlast hold their values into the next cycle.
- R11: A start strobe is ignored when the packet count is 0, when the length is 0, or when the block is busy. All configuration is sampled only when a start is accepted.
- R12: busy is 1 from the cycle after an accepted start until the last beat is accepted. done is 1 for exactly the one cycle after the last beat of a burst is accepted, with busy = 0 in that cycle.
- R13: While reset is held and after it is released, m_tvalid, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe |
| cfg_pkt_count | input | CNT_W | Packets in the burst |
| cfg_len | input | LEN_W | Payload length in 32-bit words |
| cfg_seq | input | 12 | Sequence number of the first packet |
| cfg_sid | input | 32 | Stream ID |
| cfg_time | input | 64 | Timestamp for the first packet |
| cfg_use_time | input | 1 | Put a timestamp on the first packet |
| cfg_seed_mode | input | 1 | 0 = ramp payload, 1 = seeded payload |
| cfg_seed | input | 16 | Low half of the seeded first sample |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| m_tdata | output | 64 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Last beat of a packet |

## Verification
A bad beat counter shows up at once as m_tlast on the wrong beat, and the following header then starts one beat early or late, so the mismatch appears in the same packet. A corrupted sample register or ramp base shows in the next payload beat, or in the first payload beat of the next packet. A stale sequence register or end-of-burst decision shows up in the header of the next packet. Because every accepted beat is compared, each fault is caught within one packet of where it starts.

// File: rtl/pkt_burst_gen.sv
module pkt_burst_gen #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_pkt_count,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [11:0]      cfg_seq,
  input  logic [31:0]      cfg_sid,
  input  logic [63:0]      cfg_time,
  input  logic             cfg_use_time,
  input  logic             cfg_seed_mode,
  input  logic [15:0]      cfg_seed,
  output logic             busy,
  output logic             done,
  output logic [63:0]      m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tlast
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_TIME, S_PAY} state_t;

  state_t           state;
  logic [CNT_W-1:0] pkts_left;
  logic [LEN_W-1:0] len_q, beats_left;
  logic [11:0]      seq_q;
  logic [31:0]      sid_q, samp_q, ramp_q;
  logic [63:0]      time_q;
  logic             use_time_q, mode_q, first_q, done_q;
  logic [15:0]      seed_q;

  wire fire     = m_tvalid & m_tready;
  wire has_time = first_q & use_time_q;
  wire eob      = (pkts_left == CNT_W'(1));
  wire last_pay = (beats_left == LEN_W'(1));

  logic [LEN_W:0] half_up;
  assign half_up = ({1'b0, len_q} + {{LEN_W{1'b0}}, 1'b1}) >> 1;

  logic [15:0] len_field;
  assign len_field = 16'(len_q) + (has_time ? 16'd4 : 16'd2);

  logic [31:0] samp_next;
  assign samp_next = samp_q + 32'd1;

  always_comb begin
    case (state)
      S_HDR:   m_tdata = {2'b00, has_time, eob, seq_q, len_field, sid_q};
      S_TIME:  m_tdata = time_q;
      S_PAY:   m_tdata = {samp_q, samp_next};
      default: m_tdata = '0;
    endcase
  end

  assign m_tvalid = (state != S_IDLE);
  assign m_tlast  = (state == S_PAY) & last_pay;
  assign busy     = (state != S_IDLE);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pkts_left  <= '0;
      len_q      <= '0;
      beats_left <= '0;
      seq_q      <= '0;
      sid_q      <= '0;
      samp_q     <= '0;
      ramp_q     <= '0;
      time_q     <= '0;
      use_time_q <= 1'b0;
      mode_q     <= 1'b0;
      first_q    <= 1'b0;
      seed_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && cfg_pkt_count != '0 && cfg_len != '0) begin
            state      <= S_HDR;
            pkts_left  <= cfg_pkt_count;
            len_q      <= cfg_len;
            seq_q      <= cfg_seq;
            sid_q      <= cfg_sid;
            time_q     <= cfg_time;
            use_time_q <= cfg_use_time;
            mode_q     <= cfg_seed_mode;
            seed_q     <= cfg_seed;
            ramp_q     <= '0;
            first_q    <= 1'b1;
          end
        end
        S_HDR: begin
          if (fire) begin
            state      <= has_time ? S_TIME : S_PAY;
            beats_left <= half_up[LEN_W-1:0];
            samp_q     <= mode_q ? {4'b0, seq_q, seed_q} : ramp_q;
          end
        end
        S_TIME: begin
          if (fire) state <= S_PAY;
        end
        S_PAY: begin
          if (fire) begin
            if (last_pay) begin
              ramp_q    <= ramp_q + 32'(len_q);
              seq_q     <= seq_q + 12'd1;
              pkts_left <= pkts_left - CNT_W'(1);
              first_q   <= 1'b0;
              if (eob) begin
                state  <= S_IDLE;
                done_q <= 1'b1;
              end else begin
                state <= S_HDR;
              end
            end else begin
              beats_left <= beats_left - LEN_W'(1);
              samp_q     <= samp_q + 32'd2;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_burst_gen_chk.sv
module pkt_burst_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [63:0] m_tdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic        m_tlast
);

  logic sop;
  always_ff @(posedge clk) begin
    if (!rst_n)                    sop <= 1'b1;
    else if (m_tvalid && m_tready) sop <= m_tlast;
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  p_hdr_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sop && m_tvalid |-> m_tdata[63:62] == 2'b00 && !m_tlast);

  p_done_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_tvalid && m_tready && m_tlast) && !busy);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(m_tvalid && m_tready && m_tlast) |=> busy);

endmodule

bind pkt_burst_gen pkt_burst_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
);

// File: tb/test_pkt_burst_gen.sv
`timescale 1ns/1ps
module test_pkt_burst_gen;
  localparam int CNT_W = 16;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, start, cfg_use_time, cfg_seed_mode, m_tready;
  logic [CNT_W-1:0] cfg_pkt_count;
  logic [LEN_W-1:0] cfg_len;
  logic [11:0]      cfg_seq;
  logic [31:0]      cfg_sid;
  logic [63:0]      cfg_time;
  logic [15:0]      cfg_seed;
  logic             busy, done, m_tvalid, m_tlast;
  logic [63:0]      m_tdata;

  pkt_burst_gen #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_pkt_burst_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_pkt_count(cfg_pkt_count),
    .cfg_len(cfg_len), .cfg_seq(cfg_seq), .cfg_sid(cfg_sid), .cfg_time(cfg_time),
    .cfg_use_time(cfg_use_time), .cfg_seed_mode(cfg_seed_mode), .cfg_seed(cfg_seed),
    .busy(busy), .done(done), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned rdy_pct = 100;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] hdr(input bit has, input bit eob, input logic [11:0] sq,
                                      input logic [LEN_W-1:0] len, input logic [31:0] sid);
    logic [15:0] lf;
    lf = 16'(len) + (has ? 16'd4 : 16'd2);
    return {2'b00, has, eob, sq, lf, sid};
  endfunction

  task automatic scramble();
    cfg_pkt_count = CNT_W'($urandom_range(9, 1));
    cfg_len       = LEN_W'($urandom_range(9, 1));
    cfg_seq       = 12'($urandom);
    cfg_sid       = $urandom;
    cfg_time      = {$urandom, $urandom};
    cfg_use_time  = 1'($urandom);
    cfg_seed_mode = 1'($urandom);
    cfg_seed      = 16'($urandom);
  endtask

  task automatic take_beat(input logic [63:0] exp_d, input logic exp_l, input string req);
    logic [63:0] held = '0;
    bit stalled = 1'b0;
    forever begin
      @(negedge clk);
      m_tready = ($urandom_range(99, 0) < rdy_pct);
      #1;
      if (stalled) chk(m_tvalid && m_tdata == held, "R10", m_tdata, held);
      if (m_tvalid && m_tready) break;
      stalled = m_tvalid;
      held    = m_tdata;
    end
    chk(m_tdata == exp_d, req, m_tdata, exp_d);
    chk(m_tlast == exp_l, "R7", 64'(m_tlast), 64'(exp_l));
  endtask

  task automatic run_burst(input int cnt, input int len, input logic [11:0] sq0,
                           input logic [31:0] sid, input logic [63:0] tm, input bit ut,
                           input bit mode, input logic [15:0] seed);
    logic [31:0] rb = '0;
    @(negedge clk);
    m_tready      = 1'b0;
    cfg_pkt_count = CNT_W'(cnt);
    cfg_len       = LEN_W'(len);
    cfg_seq       = sq0;
    cfg_sid       = sid;
    cfg_time      = tm;
    cfg_use_time  = ut;
    cfg_seed_mode = mode;
    cfg_seed      = seed;
    start         = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R12", 64'(busy), 64'd1);
    scramble();
    @(negedge clk);
    start = 1'b0;
    scramble();
    for (int p = 0; p < cnt; p++) begin
      logic [11:0] sq;
      logic [31:0] s;
      bit has;
      int nb;
      sq  = sq0 + 12'(p);
      has = (p == 0) && ut;
      take_beat(hdr(has, p == cnt - 1, sq, LEN_W'(len), sid), 1'b0, "R1 R2 R3 R4 R5");
      if (has) take_beat(tm, 1'b0, "R3");
      s  = mode ? {4'b0, sq, seed} : rb;
      nb = (len + 1) / 2;
      for (int b = 0; b < nb; b++) begin
        logic [31:0] a;
        a = s + 32'(2 * b);
        take_beat({a, a + 32'd1}, b == nb - 1, mode ? "R6 R9" : "R6 R8");
      end
      rb = rb + 32'(len);
    end
    @(negedge clk);
    m_tready = 1'b0;
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R12", {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R12", 64'(done), 64'd0);
  endtask

  task automatic bad_start(input int cnt, input int len);
    @(negedge clk);
    scramble();
    cfg_pkt_count = CNT_W'(cnt);
    cfg_len       = LEN_W'(len);
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(busy == 1'b0 && m_tvalid == 1'b0 && done == 1'b0, "R11",
          {61'd0, busy, m_tvalid, done}, 64'd0);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired before the bench finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    start    = 1'b0;
    m_tready = 1'b0;
    scramble();
    repeat (3) @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0 && busy == 1'b0 && done == 1'b0, "R13",
        {61'd0, m_tvalid, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0 && busy == 1'b0 && done == 1'b0, "R13",
        {61'd0, m_tvalid, busy, done}, 64'd0);

    rdy_pct = 100;
    run_burst(1, 1, 12'h005, 32'hA5A5_0001, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 16'h0);
    run_burst(3, 4, 12'h010, 32'h0000_BEEF, 64'h0, 1'b0, 1'b0, 16'h0);
    run_burst(4, 5, 12'hFFE, 32'h1234_5678, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b0, 16'h0);
    run_burst(3, 3, 12'hFFF, 32'hCAFE_F00D, 64'h1, 1'b1, 1'b1, 16'hFFFF);
    bad_start(0, 4);
    bad_start(3, 0);
    rdy_pct = 30;
    run_burst(2, 7, 12'h7FF, 32'h0BAD_0BAD, 64'hDEAD_BEEF_0000_0001, 1'b1, 1'b1, 16'h8001);
    run_burst(5, 2, 12'h000, 32'h0, 64'h0, 1'b0, 1'b0, 16'h0);

    for (int i = 0; i < 25; i++) begin
      rdy_pct = $urandom_range(100, 25);
      run_burst($urandom_range(5, 1), $urandom_range(9, 1), 12'($urandom), $urandom,
                {$urandom, $urandom}, 1'($urandom), 1'($urandom), 16'($urandom));
    end

    summary();
    $finish;
  end
endmodule